// File: doc/BRIEF.md
# Bit-Field Extract Execute Unit

This unit is one execute-stage slice for a custom RISC-V operation that copies a short run of adjacent bits out of a source register. The run starts at a chosen bit offset, and the copy lands at bit 0 of the destination with zeros above it. The unit is given the 32-bit instruction word and the values already read for rs1 and rs2. It returns three things: a flag saying the instruction is one of its own, the destination index with its write enable, and the result.

Two forms share one encoding. In the register form, the offset is the whole value held in rs2. In the immediate form, the 5-bit rs2 field of the instruction is the offset itself. The field length is 1 to 8 bits. Any bit taken from at or above the source width reads as zero, and the offset never wraps around. By default the outputs go through a single register stage that loads on each clock edge. The parameter `REG_OUT` switches that stage off and leaves a purely combinational path.

Top module: `bfx_unit`

## Requirements
- R1: An instruction is recognised only when opcode bits [6:0] are 0x0B and funct3 bits [14:12] are 0 or 4. Any other encoding gives out_valid=0, out_we=0, out_rd=0 and out_result=0.
- R2: funct3 = 0 selects the register form. The offset is the full 32-bit rs2_val.
- R3: The field length is instr[28:26] + 1, which gives 1 to 8 bits. Result bits at positions length and above are zero.
- R4: Result bit i equals rs1_val bit (offset + i). A source position at or beyond 32 contributes zero and does not wrap.
- R5: funct3 = 4 selects the immediate form. The offset is instr[24:20], and rs2_val has no effect.
- R6: In the register form, an rs2_val of 32 or more gives a result of zero. This holds even when its low five bits are small.
- R7: When recognised, out_rd equals instr[11:7], and out_we is 1 exactly when that index is non-zero. Writes to x0 are suppressed.
- R8: While in_valid is 0, out_valid, out_we, out_rd and out_result are all zero, even if the instruction word is a valid encoding.
- R9: With REG_OUT=1 (the default), outputs follow the inputs sampled at a rising clock edge and hold until the next edge. An active-low rst_n clears all outputs asynchronously.
- R10: Reserved encoding bits instr[31:29] and instr[25] must be zero. If any of them is set, the instruction is not recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking instr and the operands as live |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Source value the field is taken from |
| rs2_val | input | XLEN | Offset value for the register form |
| out_valid | output | 1 | Instruction recognised while strobed |
| out_we | output | 1 | Destination write enable |
| out_rd | output | 5 | Destination register index |
| out_result | output | XLEN | Zero-extended extracted field |

## Verification
The extract path is driven with fields taken from the middle of a word, from the very top bit, and from offsets where part of the window runs past bit 31. This separates a correct zero fill from a wrap-around or an off-by-one in the mask. Register offsets of exactly 32, and large values whose low five bits are small, show whether the offset is compared over its full width or truncated. Immediate-form cases use a garbage rs2_val to show that value is ignored. Foreign opcodes, foreign funct3 values, set reserved bits, rd=0 and an unstrobed valid word each show one gating term on its own.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   localparam logic [6:0] OPC_CUSTOM0 = 7'h0B;
   localparam logic [2:0] F3_REGOFF   = 3'd0;
   localparam logic [2:0] F3_IMMOFF   = 3'd4;
   localparam int         LEN_W       = 3;
   localparam int         MAX_LEN     = 2 ** LEN_W;
   localparam int         IDX_W       = 5;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_REG  = 2'd1,
      SRC_IMM  = 2'd2
   } bfx_src_e;

   typedef struct packed {
      logic             hit;
      bfx_src_e         src;
      logic [IDX_W-1:0] rd;
      logic [IDX_W-1:0] imm;
      logic [LEN_W-1:0] len_m1;
   } bfx_dec_t;

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
   import bfx_pkg::*;
(
   input  logic [31:0] instr,
   output bfx_dec_t    dec
);

   logic [6:0] opcode;
   logic [2:0] funct3;
   logic       rsv_clear;
   logic       op_match;

   assign opcode    = instr[6:0];
   assign funct3    = instr[14:12];
   assign rsv_clear = (instr[31:29] == 3'b000) && !instr[25];
   assign op_match  = (opcode == OPC_CUSTOM0) && rsv_clear;

   always_comb begin
      dec.src = SRC_NONE;
      if (op_match) begin
         unique case (funct3)
            F3_REGOFF: dec.src = SRC_REG;
            F3_IMMOFF: dec.src = SRC_IMM;
            default:   dec.src = SRC_NONE;
         endcase
      end
      dec.hit    = (dec.src != SRC_NONE);
      dec.rd     = instr[11:7];
      dec.imm    = instr[24:20];
      dec.len_m1 = instr[28:26];
   end

endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
   import bfx_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]  src_val,
   input  logic [XLEN-1:0]  offset,
   input  logic [LEN_W-1:0] len_m1,
   output logic [XLEN-1:0]  field
);

   localparam int              OFF_W = $clog2(XLEN);
   localparam logic [XLEN-1:0] LIMIT = XLEN'(XLEN);

   logic               in_range;
   logic [MAX_LEN-1:0] window;

   // offset compared at full width: no truncation aliasing
   assign in_range = (offset < LIMIT);
   // logical shift fills zeros above the top source bit
   assign window   = MAX_LEN'(src_val >> offset[OFF_W-1:0]);

   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i < MAX_LEN) begin : g_live
         assign field[i] = in_range && (LEN_W'(i) <= len_m1) && window[i];
      end else begin : g_zero
         assign field[i] = 1'b0;
      end
   end

endmodule

// File: rtl/bfx_stage.sv
module bfx_stage
   import bfx_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_valid,
   input  logic             d_we,
   input  logic [IDX_W-1:0] d_rd,
   input  logic [XLEN-1:0]  d_result,
   output logic             q_valid,
   output logic             q_we,
   output logic [IDX_W-1:0] q_rd,
   output logic [XLEN-1:0]  q_result
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_valid  <= 1'b0;
            q_we     <= 1'b0;
            q_rd     <= '0;
            q_result <= '0;
         end else begin
            q_valid  <= d_valid;
            q_we     <= d_we;
            q_rd     <= d_rd;
            q_result <= d_result;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_valid    = d_valid;
      assign q_we       = d_we;
      assign q_rd       = d_rd;
      assign q_result   = d_result;
   end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
   import bfx_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      instr,
   input  logic [XLEN-1:0]  rs1_val,
   input  logic [XLEN-1:0]  rs2_val,
   output logic             out_valid,
   output logic             out_we,
   output logic [IDX_W-1:0] out_rd,
   output logic [XLEN-1:0]  out_result
);

   if (XLEN < 32 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("bfx_unit: XLEN must be a power of two of at least 32");
   end
   if (MAX_LEN > XLEN) begin : g_bad_len
      $error("bfx_unit: field length cannot exceed XLEN");
   end

   bfx_dec_t        dec;
   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] field;
   logic            c_valid;
   logic            c_we;
   logic [IDX_W-1:0] c_rd;
   logic [XLEN-1:0] c_result;

   bfx_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   assign offset = (dec.src == SRC_REG) ? rs2_val
                                        : {{(XLEN-IDX_W){1'b0}}, dec.imm};

   bfx_extract #(.XLEN(XLEN)) u_ext (
      .src_val (rs1_val),
      .offset  (offset),
      .len_m1  (dec.len_m1),
      .field   (field)
   );

   assign c_valid  = in_valid && dec.hit;
   assign c_we     = c_valid && (dec.rd != '0);
   assign c_rd     = c_valid ? dec.rd : '0;
   assign c_result = c_valid ? field  : '0;

   bfx_stage #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_valid  (c_valid),
      .d_we     (c_we),
      .d_rd     (c_rd),
      .d_result (c_result),
      .q_valid  (out_valid),
      .q_we     (out_we),
      .q_rd     (out_rd),
      .q_result (out_result)
   );

endmodule

// File: rtl/bfx_chk.sv
module bfx_chk #(
   parameter int XLEN    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [6:0]      op,
   input logic [2:0]      f3,
   input logic [3:0]      rsv,
   input logic            rs2_big,
   input logic            out_valid,
   input logic            out_we,
   input logic [4:0]      out_rd,
   input logic [XLEN-1:0] out_result
);

   logic known;
   logic big_reg;
   assign known   = in_valid && (op == 7'h0B) && (rsv == 4'h0)
                    && (f3 == 3'd0 || f3 == 3'd4);
   assign big_reg = known && (f3 == 3'd0) && rs2_big;

   if (REG_OUT) begin : g_seq
      // R1 R9
      recog_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         known |=> out_valid);
      // R1 R10
      reject_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !known |=> !out_valid);
      // R6
      far_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
         big_reg |=> (out_result == '0));
   end else begin : g_cmb
      // R1 R10
      recog_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == known);
      // R6
      far_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
         big_reg |-> (out_result == '0));
   end

   // R3
   field_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_result[XLEN-1:8] == '0);
   // R8
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_result == '0 && !out_we && out_rd == '0));
   // R7
   we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |-> (out_valid && out_rd != '0));
   // R7
   we_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_rd != '0) |-> out_we);

endmodule

bind bfx_unit bfx_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_bfx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .op         (instr[6:0]),
   .f3         (instr[14:12]),
   .rsv        ({instr[31:29], instr[25]}),
   .rs2_big    (|rs2_val[XLEN-1:5]),
   .out_valid  (out_valid),
   .out_we     (out_we),
   .out_rd     (out_rd),
   .out_result (out_result)
);

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;

   typedef struct packed {
      logic [6:0]  op;
      logic [2:0]  f3;
      logic [2:0]  lm1;
      logic        rsv;
      logic [4:0]  f2;
      logic [4:0]  rd;
      logic [31:0] a;
      logic [31:0] b;
      logic        v;
      logic        we;
      logic [31:0] res;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{7'h0B, 3'd0, 3'd7, 1'b0, 5'd2,  5'd5,  32'h1234_5678, 32'd4,         1'b1, 1'b1, 32'h67},
      '{7'h0B, 3'd0, 3'd0, 1'b0, 5'd2,  5'd1,  32'h8000_0000, 32'd31,        1'b1, 1'b1, 32'h1},
      '{7'h0B, 3'd0, 3'd7, 1'b0, 5'd2,  5'd3,  32'hF000_0000, 32'd28,        1'b1, 1'b1, 32'h0F},
      '{7'h0B, 3'd0, 3'd3, 1'b0, 5'd2,  5'd2,  32'hFFFF_FFFF, 32'd32,        1'b1, 1'b1, 32'h0},
      '{7'h0B, 3'd0, 3'd7, 1'b0, 5'd2,  5'd2,  32'hFFFF_FFFF, 32'h8000_0002, 1'b1, 1'b1, 32'h0},
      '{7'h0B, 3'd4, 3'd2, 1'b0, 5'd9,  5'd7,  32'h0000_0E00, 32'd0,         1'b1, 1'b1, 32'h7},
      '{7'h0B, 3'd4, 3'd7, 1'b0, 5'd30, 5'd8,  32'hC000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h3},
      '{7'h0B, 3'd4, 3'd4, 1'b0, 5'd0,  5'd0,  32'hABCD_EF5A, 32'd0,         1'b1, 1'b0, 32'h1A},
      '{7'h0B, 3'd2, 3'd7, 1'b0, 5'd2,  5'd5,  32'h1234_5678, 32'd4,         1'b0, 1'b0, 32'h0},
      '{7'h33, 3'd0, 3'd7, 1'b0, 5'd2,  5'd5,  32'h1234_5678, 32'd4,         1'b0, 1'b0, 32'h0},
      '{7'h0B, 3'd0, 3'd5, 1'b0, 5'd2,  5'd31, 32'h0000_0FC0, 32'd6,         1'b1, 1'b1, 32'h3F},
      '{7'h0B, 3'd4, 3'd1, 1'b0, 5'd31, 5'd4,  32'h8000_0000, 32'd0,         1'b1, 1'b1, 32'h1},
      '{7'h0B, 3'd0, 3'd7, 1'b1, 5'd2,  5'd5,  32'h1234_5678, 32'd4,         1'b0, 1'b0, 32'h0}
   };

   string vtag [NV];

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] instr;
   logic [31:0] rs1_val;
   logic [31:0] rs2_val;
   logic        out_valid;
   logic        out_we;
   logic [4:0]  out_rd;
   logic [31:0] out_result;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   bfx_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .instr      (instr),
      .rs1_val    (rs1_val),
      .rs2_val    (rs2_val),
      .out_valid  (out_valid),
      .out_we     (out_we),
      .out_rd     (out_rd),
      .out_result (out_result)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc(input vec_t t);
      return {3'b000, t.lm1, t.rsv, t.f2, 5'd1, t.f3, t.rd, t.op};
   endfunction

   task automatic drive(input vec_t t, input logic vld);
      instr    = enc(t);
      rs1_val  = t.a;
      rs2_val  = t.b;
      in_valid = vld;
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      vtag = '{"R4 R2", "R4 R3", "R4 no wrap", "R6", "R6 full width",
               "R5", "R5 R4", "R7 rd0", "R1 funct3", "R1 opcode",
               "R3 R7", "R5 R4 top", "R10"};
      rst_n    = 1'b0;
      in_valid = 1'b0;
      instr    = '0;
      rs1_val  = '0;
      rs2_val  = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(out_valid == 1'b0 && out_we == 1'b0, "R9 reset flags",
            {30'd0, out_valid, out_we}, 32'h0);
      check(out_result == '0 && out_rd == '0, "R9 reset data",
            out_result, 32'h0);
      rst_n = 1'b1;

      // table walk: each vector sampled one edge after it is driven
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VECS[k], 1'b1);
         @(negedge clk);
         check(out_valid == VECS[k].v && out_we == VECS[k].we,
               {vtag[k], " flags"}, {30'd0, out_valid, out_we},
               {30'd0, VECS[k].v, VECS[k].we});
         check(out_result == VECS[k].res && out_rd == (VECS[k].v ? VECS[k].rd : 5'd0),
               {vtag[k], " result"}, out_result, VECS[k].res);
      end

      // R8: valid encoding without strobe stays silent
      @(negedge clk);
      drive(VECS[0], 1'b0);
      @(negedge clk);
      check(out_valid == 1'b0 && out_we == 1'b0 && out_rd == '0,
            "R8 flags", {30'd0, out_valid, out_we}, 32'h0);
      check(out_result == '0, "R8 result", out_result, 32'h0);

      // R9: output changes only at the edge after the strobe
      drive(VECS[1], 1'b1);
      #5;
      check(out_valid == 1'b0, "R9 before edge", {31'd0, out_valid}, 32'h0);
      @(negedge clk);
      check(out_valid == 1'b1 && out_result == 32'h1, "R9 after edge",
            out_result, 32'h1);
      in_valid = 1'b0;
      #3;
      check(out_result == 32'h1, "R9 hold", out_result, 32'h1);

      // R5: immediate form unaffected by a different rs2_val
      @(negedge clk);
      drive(VECS[5], 1'b1);
      rs2_val = 32'h0000_0001;
      @(negedge clk);
      check(out_result == 32'h7, "R5 rs2 ignored", out_result, 32'h7);

      // R9: asynchronous reset clears a live output
      #2;
      rst_n = 1'b0;
      #1;
      check(out_valid == 1'b0 && out_result == '0, "R9 async reset",
            out_result, 32'h0);
      @(negedge clk);
      rst_n    = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule